// File: doc/BRIEF.md
# Stoppable Shared Counter

This block is the global time base of an interrupt controller. A single 32-bit counter advances by one on each enable tick. The counter value fans out to one compare unit per core, and each compare unit gives a one-cycle match pulse when the counter takes on that core's compare value. Software reaches the block through a small register port. Writes are captured on the clock edge. Reads are combinational from the address.

Software can freeze the counter through a stop bit in a configuration register. While the counter is frozen, software may load a new value. A load attempted while the counter runs is dropped. The configuration register also reports the build-time sizes: the number of interrupt sources and the number of cores. The counter's low word can be read from two windows: the privileged window and a user-visible window. The user window is read-only. Both high words read as zero, because counters wider than 32 bits are not built.

Top module: `shctr_top`

## Requirements
- R1: After reset the counter holds 0, the stop bit is 0 (the counter runs), and every match output is 0.
- R2: While the stop bit is 0, the counter increases by 1 on each clock edge where `tick_i` is 1, and holds its value on edges where `tick_i` is 0.
- R3: Incrementing from 0xFFFFFFFF gives 0.
- R4: A write to address 0x00 sets the stop bit to bit 24 of the written data, which takes effect from the next cycle. Writing 1 freezes the counter so that ticks have no effect. Writing 0 resumes counting. Writing the value the bit already holds changes nothing.
- R5: A write to address 0x08 loads the written data into the counter only when the stop bit is 1. While the counter runs, such a write is ignored.
- R6: Reads of address 0x08 and address 0x20 both return the counter. Address 0x0C, address 0x24 and every unmapped address read 0. Writes to 0x20 and 0x24 change nothing.
- R7: A read of address 0x00 returns the following fields, with every other bit 0:
  - bits [7:0] hold NUM_SRC/8-1;
  - bits [14:8] hold NUM_CORES;
  - bits [19:16] hold 0 (the counter-width code);
  - bit 24 holds the live stop bit.
- R8: `match_o[c]` is 1 for exactly the cycle after an edge on which the counter takes a new value equal to core c's compare value. An edge on which the counter takes no new value produces no pulse, so a frozen counter produces no pulses unless it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address for both reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| cmp_val_i | input | NUM_CORES*32 | Compare value for each core; core c uses bits [32c+31:32c] |
| count_o | output | 32 | Current counter value |
| match_o | output | NUM_CORES | One-cycle match pulse for each core |

## Verification
A wrong counter state shows on `count_o` and in the low-word reads at the very next sampling point. Because the bench reference model is compared every cycle, a missed or extra increment is reported within one clock. A wrong stop bit shows in bit 24 of the configuration read in the same cycle. It also shows one cycle later, either as a tick that fails to advance the counter or as a load that is honoured when it should be ignored. A wrong compare path shows as a missing, duplicated or misplaced pulse on `match_o` in the cycle after the counter update.

// File: rtl/shctr_pkg.sv
package shctr_pkg;

    localparam int unsigned CTR_W = 32;

    // register byte offsets
    localparam int unsigned OFS_CFG    = 'h00;
    localparam int unsigned OFS_CNT_LO = 'h08;
    localparam int unsigned OFS_CNT_HI = 'h0C;
    localparam int unsigned OFS_USR_LO = 'h20;
    localparam int unsigned OFS_USR_HI = 'h24;

    // configuration register field layout
    localparam int unsigned CFG_SRC_LSB  = 0;
    localparam int unsigned CFG_SRC_W    = 8;
    localparam int unsigned CFG_CORE_LSB = 8;
    localparam int unsigned CFG_CORE_W   = 7;
    localparam int unsigned CFG_WID_LSB  = 16;
    localparam int unsigned CFG_WID_W    = 4;
    localparam int unsigned CFG_STOP_BIT = 24;

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             stop;
    } ctr_state_t;

    typedef struct packed {
        logic cfg;
        logic cnt_lo;
        logic cnt_hi;
        logic usr_lo;
        logic usr_hi;
    } reg_sel_t;

endpackage

// File: rtl/shctr_decode.sv
module shctr_decode
    import shctr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    always_comb begin
        sel_o        = '0;
        sel_o.cfg    = (addr_i == ADDR_W'(OFS_CFG));
        sel_o.cnt_lo = (addr_i == ADDR_W'(OFS_CNT_LO));
        sel_o.cnt_hi = (addr_i == ADDR_W'(OFS_CNT_HI));
        sel_o.usr_lo = (addr_i == ADDR_W'(OFS_USR_LO));
        sel_o.usr_hi = (addr_i == ADDR_W'(OFS_USR_HI));
    end

endmodule

// File: rtl/shctr_count.sv
module shctr_count
    import shctr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             cfg_wr_i,
    input  logic             stop_wdata_i,
    input  logic             lo_wr_i,
    input  logic [CTR_W-1:0] wdata_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic             stop_o,
    output logic             upd_o,
    output logic [CTR_W-1:0] nxt_o
);

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        upd_o = 1'b0;
        if (st_q.stop) begin
            // frozen: only a software load moves the value
            if (lo_wr_i) begin
                st_d.cnt = wdata_i;
                upd_o    = 1'b1;
            end
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + CTR_W'(1);
            upd_o    = 1'b1;
        end
        if (cfg_wr_i) begin
            st_d.stop = stop_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign stop_o = st_q.stop;
    assign nxt_o  = st_d.cnt;

endmodule

// File: rtl/shctr_match.sv
module shctr_match
    import shctr_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       upd_i,
    input  logic [CTR_W-1:0]           nxt_i,
    input  logic [NUM_CORES*CTR_W-1:0] cmp_i,
    output logic [NUM_CORES-1:0]       hit_o
);

    logic [NUM_CORES-1:0] hit_d, hit_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        always_comb begin
            hit_d[c] = upd_i && (nxt_i == cmp_i[c*CTR_W +: CTR_W]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hit_q <= '0;
        end else begin
            hit_q <= hit_d;
        end
    end

    assign hit_o = hit_q;

endmodule

// File: rtl/shctr_top.sv
module shctr_top
    import shctr_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       tick_i,
    input  logic                       reg_wr_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic [CTR_W-1:0]           reg_wdata_i,
    output logic [CTR_W-1:0]           reg_rdata_o,
    input  logic [NUM_CORES*CTR_W-1:0] cmp_val_i,
    output logic [CTR_W-1:0]           count_o,
    output logic [NUM_CORES-1:0]       match_o
);

    localparam int unsigned SRC_CODE  = NUM_SRC / 8 - 1;
    localparam int unsigned CORE_CODE = NUM_CORES;

    reg_sel_t         sel;
    logic [CTR_W-1:0] cnt_q;
    logic             stop_q;
    logic             upd;
    logic [CTR_W-1:0] nxt;
    logic [CTR_W-1:0] cfg_word;

    shctr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (reg_addr_i),
        .sel_o  (sel)
    );

    shctr_count u_count (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .cfg_wr_i     (reg_wr_i && sel.cfg),
        .stop_wdata_i (reg_wdata_i[CFG_STOP_BIT]),
        .lo_wr_i      (reg_wr_i && sel.cnt_lo),
        .wdata_i      (reg_wdata_i),
        .cnt_o        (cnt_q),
        .stop_o       (stop_q),
        .upd_o        (upd),
        .nxt_o        (nxt)
    );

    shctr_match #(.NUM_CORES(NUM_CORES)) u_match (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (upd),
        .nxt_i  (nxt),
        .cmp_i  (cmp_val_i),
        .hit_o  (match_o)
    );

    always_comb begin
        cfg_word = '0;
        cfg_word[CFG_SRC_LSB  +: CFG_SRC_W]  = CFG_SRC_W'(SRC_CODE);
        cfg_word[CFG_CORE_LSB +: CFG_CORE_W] = CFG_CORE_W'(CORE_CODE);
        cfg_word[CFG_WID_LSB  +: CFG_WID_W]  = '0;
        cfg_word[CFG_STOP_BIT]               = stop_q;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (sel.cfg) begin
            reg_rdata_o = cfg_word;
        end else if (sel.cnt_lo || sel.usr_lo) begin
            reg_rdata_o = cnt_q;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/shctr_chk.sv
module shctr_chk
    import shctr_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 tick_i,
    input logic                 reg_wr_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [CTR_W-1:0]     reg_wdata_i,
    input logic [CTR_W-1:0]     reg_rdata_o,
    input logic [CTR_W-1:0]     count_o,
    input logic [NUM_CORES-1:0] match_o,
    input logic                 stop_q
);

    logic lo_wr, cfg_wr;
    assign lo_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CNT_LO));
    assign cfg_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CFG));

    // R2
    run_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_q && tick_i) |=> (count_o == $past(count_o) + CTR_W'(1)));

    // R2
    run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_q && !tick_i) |=> $stable(count_o));

    // R5
    stopped_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_q && lo_wr) |=> (count_o == $past(reg_wdata_i)));

    // R4
    stopped_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_q && !lo_wr) |=> $stable(count_o));

    // R4
    stop_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_wr |=> (stop_q == $past(reg_wdata_i[CFG_STOP_BIT])));

    // R4
    stop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wr |=> $stable(stop_q));

    // R8
    no_match_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_q && !lo_wr) |=> (match_o == '0));

    // R6
    hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((reg_addr_i == ADDR_W'(OFS_CNT_HI)) || (reg_addr_i == ADDR_W'(OFS_USR_HI)))
        |-> (reg_rdata_o == '0));

    // R7
    cfg_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADDR_W'(OFS_CFG)) |-> (reg_rdata_o[CFG_STOP_BIT] == stop_q));

endmodule

bind shctr_top shctr_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .count_o     (count_o),
    .match_o     (match_o),
    .stop_q      (stop_q)
);

// File: tb/shctr_tb.sv
`timescale 1ns/1ps
module shctr_top_tb_top;

    localparam int NSRC  = 64;
    localparam int NCORE = 4;
    localparam int AW    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCORE*32-1:0] cmp = {32'd3, 32'hFFFF_FFFF, 32'd10, 32'd5};
    logic [31:0]       count;
    logic [NCORE-1:0]  match;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    shctr_top #(.NUM_SRC(NSRC), .NUM_CORES(NCORE), .ADDR_W(AW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .cmp_val_i   (cmp),
        .count_o     (count),
        .match_o     (match)
    );

    // behavioural reference model
    logic [31:0]      m_cnt = '0;
    bit               m_stop = 1'b0;
    logic [NCORE-1:0] m_match = '0;

    always @(posedge clk) begin
        bit          upd;
        logic [31:0] nxt;
        if (!rst_n) begin
            m_cnt = '0; m_stop = 1'b0; m_match = '0;
        end else begin
            upd = 1'b0;
            nxt = m_cnt;
            if (m_stop) begin
                if (wr && addr == 6'h08) begin upd = 1'b1; nxt = wdata; end
            end else if (tick) begin
                upd = 1'b1; nxt = m_cnt + 32'd1;
            end
            for (int c = 0; c < NCORE; c++)
                m_match[c] = upd && (nxt == cmp[c*32 +: 32]);
            m_cnt = nxt;
            if (wr && addr == 6'h00) m_stop = wdata[24];
        end
    end

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            6'h00:        return 32'(NSRC/8-1) | (32'(NCORE) << 8) | (32'(m_stop) << 24);
            6'h08, 6'h20: return m_cnt;
            default:      return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 count", count, m_cnt);
            check("R8 match", 32'(match), 32'(m_match));
            if (addr == 6'h00) check("R7 cfg read", rdata, exp_read(addr));
            else               check("R6 window read", rdata, exp_read(addr));
        end
    end

    task automatic drive(input logic t, input logic w, input logic [AW-1:0] a,
                         input logic [31:0] d);
        @(posedge clk); #1;
        tick = t; wr = w; addr = a; wdata = d;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    logic [AW-1:0] rd_list [6] = '{6'h00, 6'h08, 6'h0C, 6'h20, 6'h24, 6'h30};

    task automatic free_run(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[3], 1'b0, rd_list[i % 6], 32'd0);
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count, 32'd0);
        check("R1 match", 32'(match), 32'd0);
        check("R1 stop bit", 32'(rdata[24]), 32'd0);

        free_run(40);

        // R5 load while running is ignored
        drive(1'b0, 1'b0, 6'h08, 32'd0);
        @(negedge clk); v = count;
        drive(1'b0, 1'b1, 6'h08, 32'h0000_1234);
        drive(1'b0, 1'b0, 6'h08, 32'd0);
        @(negedge clk);
        check("R5 running load ignored", count, v);

        // R4 stop
        drive(1'b1, 1'b1, 6'h00, 32'h0100_0000);
        drive(1'b0, 1'b0, 6'h00, 32'd0);
        @(negedge clk); v = count;
        check("R4 stop bit set", 32'(rdata[24]), 32'd1);
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        drive(1'b1, 1'b1, 6'h00, 32'h01FF_FFFF); // same stop value, other bits junk
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        @(negedge clk);
        check("R4 frozen under ticks", count, v);
        check("R4 same-value write keeps stop", 32'(rdata[24]), 32'd1);

        // R8 load equal to core 1 compare gives one pulse
        drive(1'b1, 1'b1, 6'h08, 32'd10);
        drive(1'b1, 1'b0, 6'h08, 32'd0);
        @(negedge clk);
        check("R5 stopped load", count, 32'd10);
        check("R8 pulse on load", 32'(match), 32'b0010);
        drive(1'b1, 1'b0, 6'h08, 32'd0);
        @(negedge clk);
        check("R8 single cycle", 32'(match), 32'd0);

        // R6 user window write ignored
        drive(1'b0, 1'b1, 6'h20, 32'h0000_ABCD);
        drive(1'b0, 1'b1, 6'h24, 32'h0000_5555);
        drive(1'b0, 1'b0, 6'h20, 32'd0);
        @(negedge clk);
        check("R6 user write ignored", count, 32'd10);
        drive(1'b0, 1'b0, 6'h24, 32'd0);
        @(negedge clk);
        check("R6 user high zero", rdata, 32'd0);

        // R3 wrap
        drive(1'b0, 1'b1, 6'h08, 32'hFFFF_FFFD);
        drive(1'b0, 1'b1, 6'h00, 32'h0000_0000);
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        drive(1'b1, 1'b0, 6'h00, 32'd0);
        drive(1'b0, 1'b0, 6'h00, 32'd0);
        @(negedge clk);
        check("R3 wrap to zero", count, 32'd0);
        check("R4 restart clears stop", 32'(rdata[24]), 32'd0);

        // R4 restart write of same value, then more running
        drive(1'b1, 1'b1, 6'h00, 32'h0000_00FF);
        free_run(30);
        drive(1'b0, 1'b0, 6'h00, 32'd0);
        @(negedge clk);
        check("R7 cfg fields", rdata, 32'h0000_0407);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule